// File: doc/BRIEF.md
# Injector Output Fault Filter Timers

This block qualifies the raw fault indications of four low-side injector drivers before they reach the status register. Each channel receives four comparator flags: current limit, open load while on, open load while off, and thermal limit. A flag only counts as a fault after it has persisted without a break for its own filter time. The current-limit filter runs on a microsecond timebase, with a default of 60 µs. The off-state open-load filter also runs on that timebase, with a default of 250 µs, inside the 100 to 400 µs window. The on-state open-load filter runs on a slower timebase of 100 µs steps, with a default of 75 steps, which is 7.5 ms.

A qualified short to battery latches the channel's driver off. The driver stays off until the channel's command goes off, or until the status is read. Fault bits are sticky and are cleared by a one-cycle status-read pulse. A fault that qualifies in the same cycle as the read is kept.

Top module: `ffl_injector_faults`

## Requirements
- R1: After synchronous reset every fault output is 0, and `drv_on` equals `cmd_on` while no shutdown is latched.
- R2: `drv_on[i]` is high only when `cmd_on[i]` is high. With no shutdown latched it follows `cmd_on[i]` in the same cycle.
- R3: `raw_ilim[i]` held high while `drv_on[i]` is high for SHORT_US microseconds (US_DIV clocks each) sets `flt_short[i]` and forces `drv_on[i]` low. The bit is not set before (SHORT_US-1)·US_DIV clocks and is set by (SHORT_US+1)·US_DIV+2 clocks.
- R4: A break of one or more clocks in a raw condition restarts its filter from zero. Current-limit pulses each shorter than (SHORT_US-1)·US_DIV clocks never set `flt_short`, however many of them arrive.
- R5: `raw_open_on[i]` qualifies after ONOPEN_SLOW slow steps (SLOW_US·US_DIV clocks each), and only while `cmd_on[i]` is high. While the command is low the raw flag leaves `flt_open_on[i]` at 0.
- R6: `raw_open_off[i]` qualifies after OFFOPEN_US microseconds, and only while `cmd_on[i]` is low and `off_open_en` is high. Otherwise it leaves `flt_open_off[i]` at 0.
- R7: A latched shutdown is released when `cmd_on[i]` goes low. When the command returns high, `drv_on[i]` is high again, while `flt_short[i]` stays set.
- R8: A high `status_clr` at a clock edge clears all fault bits and every latched shutdown. A fault that qualifies at that same edge is set, because set wins over clear.
- R9: `raw_tlim[i]` sets `flt_tlim[i]` at the next clock edge, without filtering, and the bit stays set after the raw flag falls.
- R10: Channels are independent: a fault on one channel changes no other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | NCH | Commanded driver state per channel |
| off_open_en | input | 1 | Enables off-state open-load qualification |
| status_clr | input | 1 | One-cycle status read: clears fault bits and shutdowns |
| raw_ilim | input | NCH | Raw current-limit comparator flags |
| raw_open_on | input | NCH | Raw on-state open-load flags |
| raw_open_off | input | NCH | Raw off-state open-load flags |
| raw_tlim | input | NCH | Raw thermal-limit flags |
| drv_on | output | NCH | Gate command after short shutdown |
| flt_short | output | NCH | Latched short-to-battery faults |
| flt_open_on | output | NCH | Latched on-state open-load faults |
| flt_open_off | output | NCH | Latched off-state open-load faults |
| flt_tlim | output | NCH | Latched thermal-limit faults |

## Verification
The status-read clear and a new fault qualification can land on the same clock edge. That collision is the one that could silently lose a fault. The bench provokes it by raising a thermal flag on one channel in the very cycle that `status_clr` is pulsed, while other channels hold older sticky bits. The fresh bit must be present after the edge, and every older bit must be gone. Filter windows are judged by a lower and an upper sample time that the bench computes from the tick periods, so the unknown phase of the timebase does not matter.

// File: rtl/ffl_pkg.sv
package ffl_pkg;

    typedef struct packed {
        logic ilim;
        logic open_on;
        logic open_off;
        logic therm;
    } chan_raw_t;

    typedef struct packed {
        logic bat_short;
        logic open_on;
        logic open_off;
        logic therm;
    } chan_flt_t;

    // counter width able to hold values 0..lim
    function automatic int cnt_w(input int lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/ffl_timebase.sv
module ffl_timebase #(
    parameter int US_DIV  = 200,
    parameter int SLOW_US = 100
) (
    input  logic clk,
    input  logic rst,
    output logic us_tick,
    output logic slow_tick
);
    localparam int DW = ffl_pkg::cnt_w(US_DIV);
    localparam int SW = ffl_pkg::cnt_w(SLOW_US);

    logic [DW-1:0] div_q;
    logic [SW-1:0] slow_q;

    assign us_tick   = (div_q == DW'(US_DIV - 1));
    assign slow_tick = us_tick && (slow_q == SW'(SLOW_US - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            slow_q <= '0;
        end else if (us_tick) begin
            div_q <= '0;
            if (slow_q == SW'(SLOW_US - 1)) slow_q <= '0;
            else                            slow_q <= slow_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ffl_filter.sv
module ffl_filter #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic tick,
    output logic expired
);
    localparam int CW = ffl_pkg::cnt_w(LIMIT);

    logic [CW-1:0] cnt_q;

    assign expired = cond && (cnt_q == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !cond)                      cnt_q <= '0;
        else if (tick && cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ffl_channel.sv
module ffl_channel
    import ffl_pkg::*;
#(
    parameter int SHORT_US    = 60,
    parameter int ONOPEN_SLOW = 75,
    parameter int OFFOPEN_US  = 250
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      us_tick,
    input  logic      slow_tick,
    input  logic      cmd_on,
    input  logic      off_en,
    input  logic      clr,
    input  chan_raw_t raw,
    output logic      drv_on,
    output chan_flt_t flt
);
    logic      sd_q;
    chan_flt_t flt_q;
    logic      short_exp, onopen_exp, offopen_exp;

    assign drv_on = cmd_on & ~sd_q;
    assign flt    = flt_q;

    ffl_filter #(.LIMIT(SHORT_US)) u_short (
        .clk(clk), .rst(rst), .cond(raw.ilim & drv_on),
        .tick(us_tick), .expired(short_exp));

    ffl_filter #(.LIMIT(ONOPEN_SLOW)) u_onopen (
        .clk(clk), .rst(rst), .cond(raw.open_on & cmd_on),
        .tick(slow_tick), .expired(onopen_exp));

    ffl_filter #(.LIMIT(OFFOPEN_US)) u_offopen (
        .clk(clk), .rst(rst), .cond(raw.open_off & ~cmd_on & off_en),
        .tick(us_tick), .expired(offopen_exp));

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_q  <= 1'b0;
            flt_q <= '0;
        end else begin
            sd_q              <= (sd_q & ~clr & cmd_on) | short_exp;
            flt_q.bat_short   <= (flt_q.bat_short & ~clr) | short_exp;
            flt_q.open_on     <= (flt_q.open_on   & ~clr) | onopen_exp;
            flt_q.open_off    <= (flt_q.open_off  & ~clr) | offopen_exp;
            flt_q.therm       <= (flt_q.therm     & ~clr) | raw.therm;
        end
    end
endmodule

// File: rtl/ffl_injector_faults.sv
module ffl_injector_faults
    import ffl_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int US_DIV      = 200,
    parameter int SLOW_US     = 100,
    parameter int SHORT_US    = 60,
    parameter int ONOPEN_SLOW = 75,
    parameter int OFFOPEN_US  = 250
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cmd_on,
    input  logic           off_open_en,
    input  logic           status_clr,
    input  logic [NCH-1:0] raw_ilim,
    input  logic [NCH-1:0] raw_open_on,
    input  logic [NCH-1:0] raw_open_off,
    input  logic [NCH-1:0] raw_tlim,
    output logic [NCH-1:0] drv_on,
    output logic [NCH-1:0] flt_short,
    output logic [NCH-1:0] flt_open_on,
    output logic [NCH-1:0] flt_open_off,
    output logic [NCH-1:0] flt_tlim
);
    logic us_tick, slow_tick;

    ffl_timebase #(.US_DIV(US_DIV), .SLOW_US(SLOW_US)) u_tb (
        .clk(clk), .rst(rst), .us_tick(us_tick), .slow_tick(slow_tick));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chan_raw_t raw;
        chan_flt_t flt;

        assign raw = '{ilim: raw_ilim[i], open_on: raw_open_on[i],
                       open_off: raw_open_off[i], therm: raw_tlim[i]};

        ffl_channel #(
            .SHORT_US(SHORT_US), .ONOPEN_SLOW(ONOPEN_SLOW), .OFFOPEN_US(OFFOPEN_US)
        ) u_ch (
            .clk(clk), .rst(rst), .us_tick(us_tick), .slow_tick(slow_tick),
            .cmd_on(cmd_on[i]), .off_en(off_open_en), .clr(status_clr),
            .raw(raw), .drv_on(drv_on[i]), .flt(flt));

        assign flt_short[i]    = flt.bat_short;
        assign flt_open_on[i]  = flt.open_on;
        assign flt_open_off[i] = flt.open_off;
        assign flt_tlim[i]     = flt.therm;
    end
endmodule

// File: rtl/ffl_injector_faults_chk.sv
module ffl_injector_faults_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] cmd_on,
    input logic           off_open_en,
    input logic           status_clr,
    input logic [NCH-1:0] raw_tlim,
    input logic [NCH-1:0] drv_on,
    input logic [NCH-1:0] flt_short,
    input logic [NCH-1:0] flt_open_on,
    input logic [NCH-1:0] flt_open_off,
    input logic [NCH-1:0] flt_tlim
);
    AST_DRV_WITHIN_CMD: assert property (@(posedge clk) disable iff (rst)
        (drv_on & ~cmd_on) == '0); // R2

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_SHORT_CUTS_DRIVE: assert property (@(posedge clk) disable iff (rst)
            $rose(flt_short[i]) |-> !drv_on[i]); // R3
        AST_SHORT_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
            $rose(flt_short[i]) |-> $past(drv_on[i])); // R3
        AST_ONOPEN_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
            $rose(flt_open_on[i]) |-> $past(cmd_on[i])); // R5
        AST_OFFOPEN_NEEDS_OFF: assert property (@(posedge clk) disable iff (rst)
            $rose(flt_open_off[i]) |-> $past(!cmd_on[i] && off_open_en)); // R6
        AST_TLIM_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flt_tlim[i] && !status_clr) |=> flt_tlim[i]); // R9
        AST_TLIM_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            raw_tlim[i] |=> flt_tlim[i]); // R8
    end
endmodule

bind ffl_injector_faults ffl_injector_faults_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .cmd_on(cmd_on), .off_open_en(off_open_en),
    .status_clr(status_clr), .raw_tlim(raw_tlim), .drv_on(drv_on),
    .flt_short(flt_short), .flt_open_on(flt_open_on),
    .flt_open_off(flt_open_off), .flt_tlim(flt_tlim));

// File: tb/tb_ffl_injector_faults.sv
module tb_ffl_injector_faults;
    localparam int NCH = 4, US_DIV = 4, SLOW_US = 5;
    localparam int SHORT_US = 6, ONOPEN_SLOW = 8, OFFOPEN_US = 25;

    logic clk = 1'b0, rst = 1'b1;
    logic [NCH-1:0] cmd_on = '0, raw_ilim = '0, raw_open_on = '0, raw_open_off = '0, raw_tlim = '0;
    logic off_open_en = 1'b0, status_clr = 1'b0;
    logic [NCH-1:0] drv_on, flt_short, flt_open_on, flt_open_off, flt_tlim;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ffl_injector_faults #(.NCH(NCH), .US_DIV(US_DIV), .SLOW_US(SLOW_US),
        .SHORT_US(SHORT_US), .ONOPEN_SLOW(ONOPEN_SLOW), .OFFOPEN_US(OFFOPEN_US)) dut (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .off_open_en(off_open_en),
        .status_clr(status_clr), .raw_ilim(raw_ilim), .raw_open_on(raw_open_on),
        .raw_open_off(raw_open_off), .raw_tlim(raw_tlim), .drv_on(drv_on),
        .flt_short(flt_short), .flt_open_on(flt_open_on),
        .flt_open_off(flt_open_off), .flt_tlim(flt_tlim));

    // clocks of persistence before which a fault must not be latched
    function automatic int win_lo(input int lim, input int per);
        return (lim - 1) * per;
    endfunction
    // clocks of persistence by which the fault must be latched
    function automatic int win_hi(input int lim, input int per);
        return (lim + 1) * per + 2;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 short", flt_short, '0);
        chk("R1 onopen", flt_open_on, '0);
        chk("R1 offopen", flt_open_off, '0);
        chk("R1 tlim", flt_tlim, '0);
        chk("R1 drv", drv_on, '0);
        // R2 pass-through
        cmd_on = 4'b1010;
        #1 chk("R2 follow", drv_on, 4'b1010);
        step(1);
        // R3 short on channel 0
        cmd_on = 4'b1011; raw_ilim[0] = 1'b1;
        step(win_lo(SHORT_US, US_DIV));
        chk("R3 early", flt_short, 4'b0000);
        step(win_hi(SHORT_US, US_DIV) - win_lo(SHORT_US, US_DIV));
        chk("R3 latched", flt_short, 4'b0001);
        chk("R3 shutdown", drv_on, 4'b1010);
        chk("R10 others", flt_open_on | flt_open_off | flt_tlim, 4'b0000);
        // R7 release by command cycle
        raw_ilim[0] = 1'b0; cmd_on[0] = 1'b0;
        step(2);
        cmd_on[0] = 1'b1;
        #1 chk("R7 drive back", drv_on, 4'b1011);
        chk("R7 status kept", flt_short, 4'b0001);
        step(1);
        // R8 status read clears
        status_clr = 1'b1; step(1); status_clr = 1'b0;
        chk("R8 clear", flt_short, 4'b0000);
        // R4 random short glitches on channel 1
        for (int k = 0; k < 14; k++) begin
            raw_ilim[1] = 1'b1;
            step(1 + int'($urandom % (win_lo(SHORT_US, US_DIV) - 1)));
            raw_ilim[1] = 1'b0;
            step(1 + int'($urandom % 3));
        end
        chk("R4 glitches", flt_short, 4'b0000);
        chk("R4 drive", drv_on, 4'b1011);
        // R5 on-open on ch2 commanded on, ch3 commanded off
        cmd_on = 4'b0111; raw_open_on = 4'b1100;
        step(win_lo(ONOPEN_SLOW, US_DIV * SLOW_US));
        chk("R5 early", flt_open_on, 4'b0000);
        step(win_hi(ONOPEN_SLOW, US_DIV * SLOW_US) - win_lo(ONOPEN_SLOW, US_DIV * SLOW_US));
        chk("R5 latched", flt_open_on, 4'b0100);
        raw_open_on = '0;
        // R6 off-open: disabled, then enabled; ch1 commanded on ignored
        raw_open_off = 4'b1010;
        step(150);
        chk("R6 disabled", flt_open_off, 4'b0000);
        off_open_en = 1'b1;
        step(win_lo(OFFOPEN_US, US_DIV));
        chk("R6 early", flt_open_off, 4'b0000);
        step(win_hi(OFFOPEN_US, US_DIV) - win_lo(OFFOPEN_US, US_DIV));
        chk("R6 latched", flt_open_off, 4'b1000);
        // R9 thermal
        raw_tlim[2] = 1'b1; step(1);
        chk("R9 set", flt_tlim, 4'b0100);
        raw_tlim[2] = 1'b0; step(3);
        chk("R9 sticky", flt_tlim, 4'b0100);
        // R8 set wins over clear in the same cycle
        raw_open_off = '0;
        raw_tlim[1] = 1'b1; status_clr = 1'b1;
        step(1);
        raw_tlim[1] = 1'b0; status_clr = 1'b0;
        chk("R8 set wins", flt_tlim, 4'b0010);
        chk("R8 others cleared", flt_open_on | flt_open_off | flt_short, 4'b0000);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule